// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence for one memory burst. A start strobe loads a starting column, a burst length code and an ordering bit. From the next cycle on, the block presents one column address per clock. It raises a final-beat flag on the closing beat of a fixed-length burst.

For fixed lengths of 2, 4 and 8, the beats stay inside the block of that size that contains the start column. The beats step through that block in one of two orders. The sequential order adds the beat count modulo the length. The interleaved order XORs the beat count into the low bits. The full-row mode walks every column in ascending order and wraps around the row. It runs until a terminate input stops it or a new start replaces it. The command sequencer uses the block to drive the column field of its read and write commands.

Top module: `burst_colgen`

## Requirements
- R1: While reset is held and in the cycle after it, `beat_vld_o` and `beat_last_o` are 0 and `beat_col_o` is 0.
- R2: A start in cycle n makes `beat_vld_o` 1 in cycle n+1, with `beat_col_o` equal to the `start_col_i` sampled in cycle n.
- R3: The length code `len_code_i` gives the beat count: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8. The codes 3'b100, 3'b101 and 3'b110 give one beat. `beat_last_o` is 1 only on the final beat, and `beat_vld_o` drops in the cycle after it unless a start arrives.
- R4: When `order_i`=0 and the length L is 2, 4 or 8, beat k has low offset (s+k) mod L, where s is the start's offset within its aligned L-column block.
- R5: When `order_i`=1 and the length L is 2, 4 or 8, beat k has low offset s XOR k.
- R6: For a fixed-length burst, the column bits above the L-column block keep the start column's value on every beat.
- R7: Code 3'b111 selects the full-row mode. Beat k is (start+k) mod 2^COL_W. `order_i` is ignored in this mode. `beat_last_o` stays 0 and the burst continues past the row wrap.
- R8: `stop_i` in a cycle where a burst is active makes `beat_vld_o` 0 in the next cycle. When no burst is active, `stop_i` has no effect and `beat_vld_o` stays 0.
- R9: A start during an active burst abandons that burst. The next cycle shows the first beat of the new burst.
- R10: When `start_i` and `stop_i` are both 1 in the same cycle, the start wins and the new burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst this cycle |
| start_col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the active burst |
| beat_vld_o | output | 1 | A column beat is presented |
| beat_col_o | output | COL_W | Column address of this beat |
| beat_last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench targets these cases:
- Start columns that sit at the top of their aligned block. A design that let the carry ripple upward would leave the block instead of wrapping (R4, R6).
- Interleaved starts with odd offsets. These expose a design that adds where it should XOR (R5).
- The reserved length codes. A design that decoded them as a longer burst would keep beating past a single column.
- Full-row bursts started near the top of the row, with the interleave bit set. These catch a design that ends, flags a final beat or reorders at the row wrap.
- Restarts and stops on mid-burst cycles, including the cycle where both arrive together. These catch a design that gives priority to the stop or lets one beat of the old burst leak through.

// File: rtl/burst_pkg.sv
// Shared definitions for the burst column generator.
// Assumes column width of at least 3 bits.
package burst_pkg;
    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_ROW  = 3'b111;

    // Offset mask of the aligned block for a code; reserved codes give a single beat.
    function automatic logic [7:0] blk_mask(input logic [2:0] code);
        case (code)
            LEN_2:   blk_mask = 8'h01;
            LEN_4:   blk_mask = 8'h03;
            LEN_8:   blk_mask = 8'h07;
            default: blk_mask = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/burst_seq.sv
// Beat sequencer: holds the burst context loaded by a start and steps the beat count.
// Assumes one beat per clock; a start has priority over stop and over burst end.
module burst_seq
    import burst_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             stop_i,
    output logic             act_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] mask_o,
    output logic             row_o,
    output logic             ilv_o,
    output logic             last_o
);
    logic [COL_W-1:0] mask_new;

    // Widen the package block mask to the column width.
    always_comb begin
        mask_new = '0;
        mask_new[2:0] = blk_mask(len_code_i)[2:0];
        if (len_code_i == LEN_ROW) mask_new = '1;
    end

    // Final beat of a fixed-length burst.
    assign last_o = act_o && !row_o && (cnt_o == mask_o);

    // Burst context and beat counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o  <= 1'b0;
            base_o <= '0;
            cnt_o  <= '0;
            mask_o <= '0;
            row_o  <= 1'b0;
            ilv_o  <= 1'b0;
        end else if (start_i) begin
            act_o  <= 1'b1;
            base_o <= start_col_i;
            cnt_o  <= '0;
            mask_o <= mask_new;
            row_o  <= (len_code_i == LEN_ROW);
            ilv_o  <= order_i && (len_code_i != LEN_ROW);
        end else if (act_o) begin
            if (stop_i || last_o) act_o <= 1'b0;
            else                  cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/burst_addr.sv
// Column mapper: turns base column and beat count into the beat's column.
// Assumes mask is a contiguous low-bit mask (all ones in full-row mode).
module burst_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] xr;

    // Candidate offsets for the two orderings.
    assign sum = base_i + cnt_i;
    assign xr  = base_i ^ cnt_i;

    // Per-bit choice: fixed upper bits, ordered lower bits.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = !mask_i[b] ? base_i[b] : (ilv_i ? xr[b] : sum[b]);
    end
endmodule

// File: rtl/burst_colgen.sv
// Top of the burst column address generator.
// Assumes the caller issues legal starts; outputs come from registered state.
module burst_colgen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             stop_i,
    output logic             beat_vld_o,
    output logic [COL_W-1:0] beat_col_o,
    output logic             beat_last_o
);
    logic [COL_W-1:0] base, cnt, mask;
    logic             row, ilv;

    burst_seq #(.COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
        .act_o(beat_vld_o), .base_o(base), .cnt_o(cnt), .mask_o(mask),
        .row_o(row), .ilv_o(ilv), .last_o(beat_last_o)
    );

    burst_addr #(.COL_W(COL_W)) u_addr (
        .base_i(base), .cnt_i(cnt), .mask_i(mask), .ilv_i(ilv), .col_o(beat_col_o)
    );
endmodule

// File: rtl/burst_colgen_chk.sv
// Checker for burst_colgen: tracks the burst context from the ports and checks ordering.
module burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             order_i,
    input logic             stop_i,
    input logic             beat_vld_o,
    input logic [COL_W-1:0] beat_col_o,
    input logic             beat_last_o
);
    logic [COL_W-1:0] ck_mask;
    logic             ck_row, ck_ilv;

    // Capture the context of each burst from the start inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_mask <= '0; ck_row <= 1'b0; ck_ilv <= 1'b0;
        end else if (start_i) begin
            ck_row  <= (len_code_i == 3'b111);
            ck_ilv  <= order_i && (len_code_i != 3'b111);
            case (len_code_i)
                3'b001:  ck_mask <= COL_W'(1);
                3'b010:  ck_mask <= COL_W'(3);
                3'b011:  ck_mask <= COL_W'(7);
                3'b111:  ck_mask <= '1;
                default: ck_mask <= '0;
            endcase
        end
    end

    AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> beat_vld_o && beat_col_o == $past(start_col_i)); // R2
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && beat_last_o && !start_i |=> !beat_vld_o); // R3
    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_vld_o); // R3
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && $past(beat_vld_o) && !$past(start_i) && !ck_ilv
        |-> ((beat_col_o - $past(beat_col_o)) & ck_mask) == (COL_W'(1) & ck_mask)); // R4
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && $past(beat_vld_o) && !$past(start_i)
        |-> ((beat_col_o ^ $past(beat_col_o)) & ~ck_mask) == '0); // R6
    AST_ROW_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && ck_row |-> !beat_last_o); // R7
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && stop_i && !start_i |=> !beat_vld_o); // R8
endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_colgen.sv
// Bench for burst_colgen: directed corner cases, then seeded random traffic.
module sim_burst_colgen;
    localparam int  CLK_PERIOD = 10;
    localparam int  COL_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             order_i = 1'b0;
    logic             stop_i = 1'b0;
    logic             beat_vld_o, beat_last_o;
    logic [COL_W-1:0] beat_col_o;

    int  n_chk = 0, n_err = 0;
    bit  done = 0;

    // Reference state from the requirements.
    bit               m_act = 0, m_ilv = 0;
    logic [COL_W-1:0] m_base = '0, m_k = '0;
    logic [2:0]       m_code = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_colgen #(.COL_W(COL_W)) u0 (.*);

    function automatic int blen(input logic [2:0] c);
        case (c)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] exp_col();
        logic [COL_W-1:0] m;
        if (m_code == 3'b111) return m_base + m_k;
        m = COL_W'(blen(m_code) - 1);
        if (m_ilv) return (m_base & ~m) | ((m_base ^ m_k) & m);
        return (m_base & ~m) | ((m_base + m_k) & m);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model, compare after the rising edge.
    task automatic step(input bit st, input logic [7:0] c, input logic [2:0] bl,
                        input bit il, input bit sp, input string tag);
        bit row, lst;
        @(negedge clk);
        start_i = st; start_col_i = c; len_code_i = bl; order_i = il; stop_i = sp;
        row = (m_code == 3'b111);
        lst = m_act && !row && (int'(m_k) == blen(m_code) - 1);
        if (st) begin
            m_act = 1; m_base = c; m_k = '0; m_code = bl; m_ilv = il;
        end else if (m_act) begin
            if (sp || lst) m_act = 0;
            else           m_k = m_k + 1'b1;
        end
        @(posedge clk); #1;
        chk({tag, " valid"}, 32'(beat_vld_o), 32'(m_act));
        if (m_act) begin
            chk({tag, " col"}, 32'(beat_col_o), 32'(exp_col()));
            chk({tag, " last"}, 32'(beat_last_o),
                32'(m_code != 3'b111 && int'(m_k) == blen(m_code) - 1));
        end else begin
            chk({tag, " last idle"}, 32'(beat_last_o), 32'd0);
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 8'h00, 3'b000, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset valid", 32'(beat_vld_o), 32'd0);
        chk("R1 reset last",  32'(beat_last_o), 32'd0);
        chk("R1 reset col",   32'(beat_col_o), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset", 32'(beat_vld_o), 32'd0);

        // R2 and R4: sequential 4 from offset 1 of block -> 5,6,7,4
        step(1, 8'h05, 3'b010, 0, 0, "R2 start");
        idle(4, "R4 seq4 wrap");
        // R4 and R6: sequential 8 at block top
        step(1, 8'hAF, 3'b011, 0, 0, "R6 seq8 top");
        idle(8, "R6 upper fixed");
        // R5: interleaved 8 and 4
        step(1, 8'h0B, 3'b011, 1, 0, "R5 ilv8");
        idle(8, "R5 ilv8 beats");
        step(1, 8'h31, 3'b010, 1, 0, "R5 ilv4");
        idle(4, "R5 ilv4 beats");
        // R3: single beat, pair and reserved codes
        step(1, 8'h44, 3'b000, 0, 0, "R3 len1");
        idle(2, "R3 len1 end");
        step(1, 8'h45, 3'b001, 0, 0, "R3 len2");
        idle(3, "R3 len2 end");
        for (int r = 4; r < 7; r++) begin
            step(1, 8'h66, 3'(r), 1, 0, "R3 reserved");
            idle(2, "R3 reserved end");
        end
        // R7: full row across wrap with interleave bit ignored, then stop (R8)
        step(1, 8'hFE, 3'b111, 1, 0, "R7 row start");
        idle(6, "R7 row wrap");
        step(0, 8'h00, 3'b000, 0, 1, "R8 stop row");
        idle(2, "R8 after stop");
        step(0, 8'h00, 3'b000, 0, 1, "R8 stop idle");
        idle(1, "R8 idle stays");
        // R9: restart mid-burst
        step(1, 8'h10, 3'b011, 0, 0, "R9 first");
        idle(2, "R9 first beats");
        step(1, 8'h83, 3'b010, 1, 0, "R9 restart");
        idle(4, "R9 new beats");
        // R10: start and stop together
        step(1, 8'h20, 3'b011, 0, 0, "R10 first");
        idle(1, "R10 beat");
        step(1, 8'h57, 3'b001, 0, 1, "R10 start wins");
        idle(2, "R10 new beats");

        // Seeded random traffic.
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            bit st, sp, il;
            logic [2:0] bl;
            st = ($urandom_range(7) == 0);
            sp = ($urandom_range(15) == 0);
            il = $urandom_range(1);
            bl = 3'($urandom_range(7));
            step(st, 8'($urandom), bl, il, sp,
                 (m_code == 3'b111) ? "R7 random" : (m_ilv ? "R5 random" : "R4 random"));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule